// File: doc/BRIEF.md
# Pipelined byte-write synchronous SRAM

This block is a synchronous static memory for a cache data path. It registers every clocked input on the rising edge and returns read data through an output register, one clock after the address is captured. A word is built from several 9-bit byte lanes, each made of 8 data bits and 1 parity bit. Single lanes can be written through per-lane strobes qualified by a write enable. A global write strobe writes the whole word.

The output side has an asynchronous output-enable input and a sleep input. Both gate the read port without waiting for a clock. A deselect, a write or a sleep cycle removes the drive at the same pipeline point as read data would have appeared. As a result, the data of the last read stays on the port for one more cycle after the chip is deselected. Sleep also blocks reads and writes and keeps the stored contents. The read port is modelled as a drive-enable flag plus a data bus that reads zero whenever it is not driven, which stands for high impedance.

Top module: `pbw_sram`

## Requirements
- R1: While reset is asserted and after it is released with no access issued, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: A read is a cycle with `chip_en`=1, `wr_en`=0, `gbl_wr`=0 and `sleep`=0 at rising edge T. Its word appears on `rd_data` with `rd_drive`=1 after edge T+1 and holds until edge T+2.
- R3: In a cycle with `wr_en`=1, `gbl_wr`=0 and `chip_en`=1, lane i (bits 9*i+8 down to 9*i of the word) is written when `byte_en[i]`=1. Lanes whose strobe is 0 keep their previous content.
- R4: Byte strobes with `wr_en`=0 and `gbl_wr`=0 write nothing, and the cycle is a read.
- R5: `gbl_wr`=1 with `chip_en`=1 writes every lane of the addressed word, whatever the values of `byte_en` and `wr_en`.
- R6: `wr_en`=1 with every `byte_en` bit set writes the whole word.
- R7: `wr_en`=1 with no byte strobe and `gbl_wr`=0 writes nothing and produces no read data.
- R8: A write cycle at edge T leaves `rd_drive`=0 after edge T+1.
- R9: `chip_en`=0 at edge T writes nothing and drops `rd_drive` only after edge T+1. A read captured at edge T-1 therefore stays on the port until edge T+1.
- R10: `out_en`=0 forces `rd_drive` to 0 and `rd_data` to zero at once, without a clock edge. Raising `out_en` again restores the pending read word.
- R11: While `sleep`=1, `rd_drive` is 0 and reads and writes are ignored. The stored words survive a sleep period unchanged.
- R12: A read issued in the cycle right after a write to the same address returns the newly written word. A read issued right before a write returns the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | ADDR_W (4) | Word address, registered |
| wdata | input | DATA_W (36) | Write word, registered |
| byte_en | input | LANES (4) | Per-lane write strobes, registered |
| wr_en | input | 1 | Write enable qualifying the byte strobes, registered |
| gbl_wr | input | 1 | Whole-word write strobe, registered |
| chip_en | input | 1 | Chip select, registered |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Unclocked sleep request |
| rd_data | output | DATA_W (36) | Read word, zero while not driven |
| rd_drive | output | 1 | Read port drive enable |

## Verification
The case that needs care is a write or deselect captured at the same edge on which the output register still shows the previous read. The bench provokes it with a read directly followed by a write to the same address, and with a read directly followed by a deselect. A scoreboard holds the expected port values per cycle, so the old word must be visible for exactly one more cycle before the drive drops, and the next read must show the new word. A second overlap is the asynchronous output enable falling while a read is live. The bench checks this between clock edges: the drive must vanish and then return with the same word.

// File: rtl/pbw_pkg.sv
`timescale 1ns/100ps
package pbw_pkg;

    // Kind of access held in the input register stage
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    // Address width for a given depth, never below one bit
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/pbw_write_decode.sv
`timescale 1ns/100ps
module pbw_write_decode
    import pbw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             chip_en,
    input  logic             sleep,
    input  logic             wr_en,
    input  logic             gbl_wr,
    input  logic [LANES-1:0] byte_en,
    output logic [LANES-1:0] lane_wr,
    output cyc_kind_e        kind
);

    logic active;

    // A cycle counts only when selected and awake
    assign active = chip_en & ~sleep;

    // One write qualifier per lane: global strobe, or lane strobe with enable
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = active & (gbl_wr | (wr_en & byte_en[g]));
    end

    always_comb begin
        if (!active) begin
            kind = CYC_IDLE;
        end else if (gbl_wr || wr_en) begin
            kind = CYC_WRITE;
        end else begin
            kind = CYC_READ;
        end
    end

endmodule

// File: rtl/pbw_mem_array.sv
`timescale 1ns/100ps
module pbw_mem_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    // One independent bank per byte lane, so a lane write touches only its bank
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                bank[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/pbw_read_pipe.sv
`timescale 1ns/100ps
module pbw_read_pipe #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq,
    output logic              dq_drive
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_reg_t;

    out_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = rd_req;
        if (rd_req) begin
            r_d.data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Drive gating is combinational on the unclocked controls
    assign dq_drive = r_q.valid & out_en & ~sleep;
    assign dq       = dq_drive ? r_q.data : '0;

endmodule

// File: rtl/pbw_sram.sv
`timescale 1ns/100ps
module pbw_sram
    import pbw_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 16,
    localparam int DATA_W = LANES * LANE_W,
    localparam int ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_en,
    input  logic              wr_en,
    input  logic              gbl_wr,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lane_wr;
    } stage_t;

    stage_t            stg_d, stg_q;
    logic [LANES-1:0]  dec_lane_wr;
    cyc_kind_e         dec_kind;
    logic [LANES-1:0]  mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic              rd_req;

    pbw_write_decode #(
        .LANES (LANES)
    ) u_dec (
        .chip_en (chip_en),
        .sleep   (sleep),
        .wr_en   (wr_en),
        .gbl_wr  (gbl_wr),
        .byte_en (byte_en),
        .lane_wr (dec_lane_wr),
        .kind    (dec_kind)
    );

    // Input register stage: every clocked input captured at the edge
    always_comb begin
        stg_d         = stg_q;
        stg_d.kind    = dec_kind;
        stg_d.addr    = addr;
        stg_d.wdata   = wdata;
        stg_d.lane_wr = dec_lane_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '{kind: CYC_IDLE, addr: '0, wdata: '0, lane_wr: '0};
        end else begin
            stg_q <= stg_d;
        end
    end

    // Self-timed write from the registered stage; sleep blocks it
    always_comb begin
        mem_we = '0;
        if (stg_q.kind == CYC_WRITE && !sleep) begin
            mem_we = stg_q.lane_wr;
        end
    end

    assign rd_req = (stg_q.kind == CYC_READ) & ~sleep;

    pbw_mem_array #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (stg_q.addr),
        .wdata (stg_q.wdata),
        .raddr (stg_q.addr),
        .rdata (mem_rdata)
    );

    pbw_read_pipe #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_word  (mem_rdata),
        .out_en   (out_en),
        .sleep    (sleep),
        .dq       (rd_data),
        .dq_drive (rd_drive)
    );

endmodule

// File: rtl/pbw_sram_chk.sv
`timescale 1ns/100ps
module pbw_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              gbl_wr,
    input logic              chip_en,
    input logic              out_en,
    input logic              sleep,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_drive);

    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && !wr_en && !gbl_wr && !sleep) ##1 !sleep
        |=> (rd_drive || !out_en || sleep));

    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && (wr_en || gbl_wr)) |=> ##1 !rd_drive);

    p_desel_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ##1 !rd_drive);

    p_drive_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> (out_en && !sleep));

    p_quiet_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rd_drive);

endmodule

bind pbw_sram pbw_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .gbl_wr   (gbl_wr),
    .chip_en  (chip_en),
    .out_en   (out_en),
    .sleep    (sleep),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
);

// File: tb/pbw_sram_test.sv
`timescale 1ns/100ps
module pbw_sram_test;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 16;
    localparam int W      = LANES * LANE_W;
    localparam int AW     = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic [LANES-1:0] byte_en;
    logic          wr_en, gbl_wr, chip_en, out_en, sleep;
    logic [W-1:0]  rd_data;
    logic          rd_drive;

    always #2.5 clk = ~clk;

    pbw_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .byte_en(byte_en),
        .wr_en(wr_en), .gbl_wr(gbl_wr), .chip_en(chip_en), .out_en(out_en),
        .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    typedef struct {
        logic         drive;
        logic [W-1:0] data;
        int           due;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           cyc = 0;
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] ref_mem [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic got_v, input logic exp_v,
                         input logic [W-1:0] got_d, input logic [W-1:0] exp_d);
        checks++;
        if (got_v !== exp_v || got_d !== exp_d) begin
            errors++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, got_v, got_d, exp_v, exp_d);
        end
    endtask

    // Monitor: compare port values against the scoreboard when due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, rd_drive, e.drive, rd_data, e.data);
        end
    end

    // Driver: apply one access and predict its port result two edges later
    task automatic op(input logic ce, input logic we, input logic gw,
                      input logic [LANES-1:0] be, input int a,
                      input logic [W-1:0] d, input bit chk, input string tag);
        exp_t e;
        logic active;
        @(posedge clk);
        #1;
        chip_en = ce; wr_en = we; gbl_wr = gw; byte_en = be;
        addr = AW'(a); wdata = d;
        active = ce && !sleep;
        if (active && (gw || we)) begin
            for (int i = 0; i < LANES; i++) begin
                if (gw || be[i]) ref_mem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
            end
        end
        e.drive = active && !gw && !we && out_en;
        e.data  = e.drive ? ref_mem[a] : '0;
        e.due   = cyc + 2;
        e.tag   = tag;
        if (chk) sb.push_back(e);
    endtask

    task automatic idle(input bit chk, input string tag);
        op(1'b0, 1'b0, 1'b0, '0, 0, '0, chk, tag);
    endtask

    function automatic logic [W-1:0] pat(input int a);
        return {9'(a + 1), 9'(a * 3 + 2), 9'(a * 5 + 3), 9'(a * 7 + 4)};
    endfunction

    bit done = 1'b0;

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; byte_en = '0;
        wr_en = 1'b0; gbl_wr = 1'b0; chip_en = 1'b0; out_en = 1'b1; sleep = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", rd_drive, 1'b0, rd_data, '0);
        rst_n = 1'b1;
        idle(1, "R1");
        idle(1, "R1");

        // R5: global write regardless of byte strobes and write enable
        for (int a = 0; a < DEPTH; a++) begin
            op(1, a[0], 1, 4'(a), a, pat(a), 1, "R5 write");
        end
        for (int a = 0; a < DEPTH; a++) begin
            op(1, 0, 0, '0, a, '0, 1, "R2/R5 read");
        end

        // R3: partial lane writes
        op(1, 1, 0, 4'b0101, 3, 36'hFFF_FFF_FFF, 1, "R3 write");
        op(1, 0, 0, '0, 3, '0, 1, "R3 read");
        op(1, 1, 0, 4'b1000, 7, 36'h1AB_000_000, 1, "R3 write");
        op(1, 0, 0, '0, 7, '0, 1, "R3 read");

        // R12: write then read, read then write, same address
        op(1, 1, 0, 4'b0011, 5, 36'h0_0000_3C3C, 1, "R12 write");
        op(1, 0, 0, '0, 5, '0, 1, "R12 read new");
        op(1, 0, 0, '0, 4, '0, 1, "R12 read old");
        op(1, 0, 1, '0, 4, 36'h9_8765_4321, 1, "R12 write");
        op(1, 0, 0, '0, 4, '0, 1, "R12 read new");

        // R4: byte strobes without write enable read
        op(1, 0, 0, 4'b1111, 6, 36'hDEAD_BEEF_0, 1, "R4 strobes only");
        op(1, 0, 0, '0, 6, '0, 1, "R4 unchanged");

        // R6: every strobe plus write enable writes the word
        op(1, 1, 0, 4'b1111, 9, 36'h5_A5A5_A5A5, 1, "R6 write");
        op(1, 0, 0, '0, 9, '0, 1, "R6 read");

        // R7: write enable with no strobes
        op(1, 1, 0, 4'b0000, 10, 36'hF_FFFF_FFFF, 1, "R7 no lanes");
        op(1, 0, 0, '0, 10, '0, 1, "R7 unchanged");

        // R8: write cycles keep the port quiet
        op(1, 1, 1, 4'b1111, 11, 36'h3_3333_3333, 1, "R8 write");
        op(1, 1, 0, 4'b0010, 12, 36'h0_0000_0000, 1, "R8 write");
        op(1, 0, 0, '0, 11, '0, 1, "R8 read");

        // R9: read followed by deselect, then deselected write ignored
        op(1, 0, 0, '0, 2, '0, 1, "R9 read before deselect");
        op(0, 0, 0, '0, 2, '0, 1, "R9 deselect");
        op(0, 1, 1, 4'b1111, 2, 36'h0_0000_0BAD, 1, "R9 deselected write");
        op(1, 0, 0, '0, 2, '0, 1, "R9 unchanged");

        // R10: output enable gates between edges
        op(1, 0, 0, '0, 13, '0, 0, "R10");
        idle(0, "R10");
        idle(0, "R10");
        #1;
        check("R10 live", rd_drive, 1'b1, rd_data, ref_mem[13]);
        out_en = 1'b0;
        #0.5;
        check("R10 disabled", rd_drive, 1'b0, rd_data, '0);
        out_en = 1'b1;
        #0.5;
        check("R10 restored", rd_drive, 1'b1, rd_data, ref_mem[13]);

        // R11: sleep blocks accesses and keeps contents
        repeat (3) idle(1, "R11 pre");
        sleep = 1'b1;
        #0.5;
        check("R11 asleep", rd_drive, 1'b0, rd_data, '0);
        op(1, 0, 1, '0, 0, 36'h7_7777_7777, 1, "R11 write asleep");
        op(1, 0, 0, '0, 0, '0, 1, "R11 read asleep");
        repeat (3) idle(1, "R11 asleep");
        sleep = 1'b0;
        idle(1, "R11 wake");
        op(1, 0, 0, '0, 0, '0, 1, "R11 retained");
        op(1, 0, 0, '0, 15, '0, 1, "R11 retained");

        // Mixed stream of lane writes and reads
        for (int i = 0; i < 16; i++) begin
            op(1, i[0], i[3] & i[2], 4'(i * 5), (i * 7) % DEPTH,
               pat(i + 40), 1, "R3 mixed write");
            op(1, 0, 0, 4'(i), (i * 7) % DEPTH, '0, 1, "R4 mixed read");
        end

        repeat (4) idle(1, "R9 drain");
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule